// File: doc/BRIEF.md
# System Reset Sequencer with Push-Button Debounce

This block produces the active-low system reset for a processor subsystem. It has two sources: a digital power-good flag from an external supply comparator, and a shared open-drain reset line that a push-button may pull low. The block also drives that line itself. Every reset pulse is timed in pulses of a 1 ms tick input, and the hold length is a parameter. A one-cycle timeout request from a separate watchdog block can also trigger a plain hold pulse.

When power-good drops, reset is asserted at once. When it returns, reset is held for one full hold period. If the oscillator-wait option is selected, the hold period starts only once the oscillator reports ready. A push on the button is seen as a falling edge on the synchronized line, and only while no reset cycle is running. The block answers with a debounce pulse of its own. It then releases the line, waits for the synchronizer to settle, and samples the line. If the button is still held, the block waits for the release and then drives one more full hold pulse.

Top module: `reset_sequencer`

## Requirements
- R1: After `arst_n` is released, and at any time `pwr_good` is low, `sys_rst_n` is low and `rst_line_drive` is high.
- R2: With `osc_wait_en` low, after `pwr_good` returns high the line stays driven for exactly HOLD_TICKS pulses of `ms_tick`. The drive is released on the clock edge right after the last counted tick, and `sys_rst_n` then goes high.
- R3: With `osc_wait_en` high, no tick is counted until `osc_ready` is high. Reset stays asserted for as long as `osc_ready` stays low.
- R4: `rst_line_in` passes through a SYNC_STAGES-flop synchronizer. A falling edge of the synchronized line while idle starts a debounce drive that lasts HOLD_TICKS ticks.
- R5: After the debounce drive, the line is released and sampled SYNC_STAGES+1 cycles later. If it reads high, the block returns to idle and issues no further pulse.
- R6: If the sampled line is still low, the block stops driving and keeps `sys_rst_n` low while it waits for the button to be released.
- R7: A rising edge of the synchronized line during that wait starts a release drive of HOLD_TICKS ticks. The block is idle afterwards.
- R8: Line edges that occur outside the idle state start nothing. This includes a line still held low by the button when a pulse ends, and the later release of that button.
- R9: A one-cycle `wdt_req` while idle starts a drive pulse of HOLD_TICKS ticks. `wdt_req` outside idle is ignored.
- R10: A low `pwr_good` aborts any sequence in progress. In the next cycle the block is in the power-fail state with the line driven.
- R11: `sys_rst_n` is high only in the idle state. `rst_line_drive` is never high while `sys_rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous reset of the sequencer's own flops, active low |
| pwr_good | input | 1 | Supply within tolerance, synchronous to clk |
| osc_wait_en | input | 1 | Option: delay the power-up hold until the oscillator is ready |
| osc_ready | input | 1 | Oscillator running and stable |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| wdt_req | input | 1 | One-cycle timeout request from the watchdog |
| rst_line_in | input | 1 | Sensed level of the open-drain reset line |
| rst_line_drive | output | 1 | Pulls the open-drain reset line low when high |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
The hardest situation to reach is the wait for button release. The debounce pulse must end while the button is still held, and the sampled line must reflect the button rather than the block's own fading drive. The bench holds its button model low through the whole debounce drive and the settle window, then releases it. This forces the wait state and its exit on a rising edge. A variant holds the button past the end of a watchdog pulse, which exercises the rule that edges outside idle are ignored. A further variant drops power-good during the wait to show the override.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        ST_PWRFAIL  = 3'd0,
        ST_OSCWAIT  = 3'd1,
        ST_HOLD     = 3'd2,
        ST_IDLE     = 3'd3,
        ST_DEBOUNCE = 3'd4,
        ST_SETTLE   = 3'd5,
        ST_WAITREL  = 3'd6,
        ST_RELHOLD  = 3'd7
    } seq_state_e;

endpackage

// File: rtl/rstseq_line_sync.sv
module rstseq_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic line_raw,
    output logic line_s,
    output logic fall,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              last;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.sh   = {cur_q.sh[STAGES-2:0], line_raw};
        nxt_d.last = cur_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) cur_q <= '1;
        else         cur_q <= nxt_d;
    end

    assign line_s = cur_q.sh[STAGES-1];
    assign fall   = cur_q.last & ~line_s;
    assign rise   = ~cur_q.last & line_s;

    // R4: a detected falling edge follows a synchronized high level
    p_fall_after_high_r4: assert property (@(posedge clk) disable iff (!arst_n)
        fall |-> $past(line_s));

endmodule

// File: rtl/rstseq_tick_timer.sv
module rstseq_tick_timer #(
    parameter int TICKS = 250
) (
    input  logic clk,
    input  logic arst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CNT_W = $clog2(TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    assign done = run && tick && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (!run)      cnt_d = '0;
        else if (done) cnt_d = '0;
        else if (tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // R2: the tick count never passes the hold length
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!arst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import rstseq_pkg::*;
#(
    parameter int HOLD_TICKS  = 250,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic pwr_good,
    input  logic osc_wait_en,
    input  logic osc_ready,
    input  logic ms_tick,
    input  logic wdt_req,
    input  logic rst_line_in,
    output logic rst_line_drive,
    output logic sys_rst_n
);
    localparam int SETTLE_CYC = SYNC_STAGES + 1;
    localparam int SET_W      = $clog2(SETTLE_CYC + 1);
    localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [SET_W-1:0] settle;
    } seq_t;

    seq_t cur_q, nxt_d;

    logic line_s, line_fall, line_rise;
    logic tmr_run, tmr_done;

    rstseq_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .arst_n   (arst_n),
        .line_raw (rst_line_in),
        .line_s   (line_s),
        .fall     (line_fall),
        .rise     (line_rise)
    );

    assign tmr_run = (cur_q.state == ST_HOLD) || (cur_q.state == ST_DEBOUNCE)
                  || (cur_q.state == ST_RELHOLD);

    rstseq_tick_timer #(.TICKS(HOLD_TICKS)) u_timer (
        .clk    (clk),
        .arst_n (arst_n),
        .run    (tmr_run),
        .tick   (ms_tick),
        .done   (tmr_done)
    );

    always_comb begin
        nxt_d = cur_q;
        if (!pwr_good) begin
            nxt_d.state  = ST_PWRFAIL;
            nxt_d.settle = '0;
        end else begin
            unique case (cur_q.state)
                ST_PWRFAIL:
                    nxt_d.state = (!osc_wait_en || osc_ready) ? ST_HOLD : ST_OSCWAIT;
                ST_OSCWAIT:
                    if (osc_ready) nxt_d.state = ST_HOLD;
                ST_HOLD, ST_RELHOLD:
                    if (tmr_done) nxt_d.state = ST_IDLE;
                ST_IDLE:
                    if (line_fall)    nxt_d.state = ST_DEBOUNCE;
                    else if (wdt_req) nxt_d.state = ST_HOLD;
                ST_DEBOUNCE:
                    if (tmr_done) begin
                        nxt_d.state  = ST_SETTLE;
                        nxt_d.settle = '0;
                    end
                ST_SETTLE:
                    if (cur_q.settle == SET_LAST)
                        nxt_d.state = line_s ? ST_IDLE : ST_WAITREL;
                    else
                        nxt_d.settle = cur_q.settle + 1'b1;
                ST_WAITREL:
                    if (line_rise) nxt_d.state = ST_RELHOLD;
                default:
                    nxt_d.state = ST_PWRFAIL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cur_q.state  <= ST_PWRFAIL;
            cur_q.settle <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sys_rst_n      = (cur_q.state == ST_IDLE);
    assign rst_line_drive = (cur_q.state == ST_PWRFAIL) || (cur_q.state == ST_OSCWAIT)
                         || tmr_run;

    // R1/R10: low supply forces reset and drive on the next cycle
    p_pwrfail_drive_r1: assert property (@(posedge clk) disable iff (!arst_n)
        !pwr_good |=> (!sys_rst_n && rst_line_drive));

    // R2: reset is released only with the supply good
    p_release_good_r2: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(sys_rst_n) |-> $past(pwr_good));

    // R3: no progress while the oscillator is not ready
    p_osc_gate_r3: assert property (@(posedge clk) disable iff (!arst_n)
        (cur_q.state == ST_OSCWAIT && !osc_ready) |=> !sys_rst_n);

    // R4: an idle falling edge starts the debounce drive
    p_debounce_start_r4: assert property (@(posedge clk) disable iff (!arst_n)
        (cur_q.state == ST_IDLE && pwr_good && line_fall) |=> rst_line_drive);

    // R7: release in the wait starts the second drive
    p_release_drive_r7: assert property (@(posedge clk) disable iff (!arst_n)
        (cur_q.state == ST_WAITREL && pwr_good && line_rise) |=> rst_line_drive);

    // R9: watchdog request in idle starts a pulse
    p_wdt_start_r9: assert property (@(posedge clk) disable iff (!arst_n)
        (cur_q.state == ST_IDLE && pwr_good && wdt_req) |=> rst_line_drive);

    // R11: the line is never driven while reset is released
    p_drive_in_reset_r11: assert property (@(posedge clk) disable iff (!arst_n)
        rst_line_drive |-> !sys_rst_n);

endmodule

// File: tb/reset_sequencer_test.sv
`timescale 1ns/1ps
module reset_sequencer_test;
    localparam int HOLD = 4;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic pwr_good = 1'b0;
    logic osc_wait_en = 1'b0;
    logic osc_ready = 1'b0;
    logic wdt_req = 1'b0;
    logic button = 1'b0;
    logic [2:0] tdiv = '0;
    logic ms_tick;
    logic drv, rst_n, line;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) tdiv <= tdiv + 1'b1;
    assign ms_tick = (tdiv == 3'd7);
    assign line = !(drv || button);

    reset_sequencer #(.HOLD_TICKS(HOLD), .SYNC_STAGES(2)) uut (
        .clk(clk), .arst_n(arst_n), .pwr_good(pwr_good), .osc_wait_en(osc_wait_en),
        .osc_ready(osc_ready), .ms_tick(ms_tick), .wdt_req(wdt_req),
        .rst_line_in(line), .rst_line_drive(drv), .sys_rst_n(rst_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_pulse(input string req);
        exp_q.push_back(HOLD);
        tag_q.push_back(req);
    endtask

    task automatic wait_drive(input logic v, input string req);
        int n = 0;
        while (drv !== v && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(drv === v, req, int'(drv), int'(v));
        step(1);
    endtask

    // Monitor: counts qualified ticks per drive pulse and scores against the queue
    logic prev_drv = 1'b0, prev_pg = 1'b0, prev_osc = 1'b0, prev_qtick = 1'b0;
    int tcount = 0;
    always @(negedge clk) begin
        logic qual;
        qual = pwr_good && prev_pg && (!osc_wait_en || (osc_ready && prev_osc));
        if (!pwr_good) tcount = 0;
        if (drv && !prev_drv) tcount = 0;
        if (!drv && prev_drv && arst_n) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected pulse", tcount, 0);
            end else begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(tcount == e, t, tcount, e);
                chk(prev_qtick, {t, " release edge"}, int'(prev_qtick), 1);
            end
        end
        prev_qtick = drv && ms_tick && qual;
        if (prev_qtick) tcount++;
        prev_drv = drv;
        prev_pg  = pwr_good;
        prev_osc = osc_ready;
    end

    initial begin
        step(3);
        // R1: reset state
        chk(rst_n == 1'b0, "R1 rst after reset", rst_n, 0);
        chk(drv == 1'b1, "R1 drive after reset", drv, 1);
        arst_n = 1'b1;
        expect_pulse("R2 power-up hold");
        step(40);
        chk(rst_n == 1'b0 && drv == 1'b1, "R1 held while supply low", rst_n, 0);
        pwr_good = 1'b1;
        wait_drive(1'b0, "R2");
        chk(rst_n == 1'b1, "R2 released", rst_n, 1);

        // R9: watchdog pulse
        step(5);
        expect_pulse("R9 watchdog pulse");
        wdt_req = 1'b1; step(1); wdt_req = 1'b0;
        wait_drive(1'b1, "R9");
        wait_drive(1'b0, "R9");
        step(3);
        chk(rst_n == 1'b1, "R9 idle after pulse", rst_n, 1);

        // R4/R6/R7: held button, wait, release
        expect_pulse("R4 debounce pulse");
        expect_pulse("R7 release pulse");
        button = 1'b1;
        wait_drive(1'b1, "R4");
        wait_drive(1'b0, "R4");
        step(10);
        chk(rst_n == 1'b0, "R6 reset during wait", rst_n, 0);
        chk(drv == 1'b0, "R6 no drive during wait", drv, 0);
        wdt_req = 1'b1; step(1); wdt_req = 1'b0;
        step(30);
        chk(drv == 1'b0, "R9 wdt ignored in wait", drv, 0);
        chk(rst_n == 1'b0, "R6 still waiting", rst_n, 0);
        button = 1'b0;
        wait_drive(1'b1, "R7");
        wait_drive(1'b0, "R7");
        step(5);
        chk(rst_n == 1'b1, "R7 idle after release pulse", rst_n, 1);

        // R8: button held across the end of a watchdog pulse
        step(5);
        expect_pulse("R8 watchdog pulse");
        wdt_req = 1'b1; step(1); wdt_req = 1'b0;
        wait_drive(1'b1, "R8");
        button = 1'b1;
        wait_drive(1'b0, "R8");
        step(20);
        chk(rst_n == 1'b1 && drv == 1'b0, "R8 held line ignored", rst_n, 1);
        button = 1'b0;
        step(20);
        chk(rst_n == 1'b1 && drv == 1'b0, "R8 release ignored", rst_n, 1);

        // R5: short press released during debounce
        expect_pulse("R5 debounce pulse");
        button = 1'b1;
        wait_drive(1'b1, "R5");
        button = 1'b0;
        wait_drive(1'b0, "R5");
        step(20);
        chk(rst_n == 1'b1 && drv == 1'b0, "R5 back to idle", rst_n, 1);

        // R3: oscillator gating
        osc_wait_en = 1'b1;
        osc_ready = 1'b0;
        expect_pulse("R3 oscillator-gated hold");
        pwr_good = 1'b0;
        step(10);
        pwr_good = 1'b1;
        step(100);
        chk(rst_n == 1'b0 && drv == 1'b1, "R3 waits for oscillator", rst_n, 0);
        osc_ready = 1'b1;
        wait_drive(1'b0, "R3");
        chk(rst_n == 1'b1, "R3 released", rst_n, 1);
        osc_wait_en = 1'b0;

        // R10: power fail during the release wait
        step(5);
        expect_pulse("R10 debounce pulse");
        expect_pulse("R10 power hold");
        button = 1'b1;
        wait_drive(1'b1, "R10");
        wait_drive(1'b0, "R10");
        step(10);
        chk(drv == 1'b0, "R10 in wait", drv, 0);
        pwr_good = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(drv == 1'b1 && rst_n == 1'b0, "R10 override", drv, 1);
        step(10);
        pwr_good = 1'b1;
        wait_drive(1'b0, "R10");
        step(10);
        chk(rst_n == 1'b1, "R8 held line after power hold", rst_n, 1);
        button = 1'b0;
        step(20);
        chk(rst_n == 1'b1 && drv == 1'b0, "R8 release ignored", rst_n, 1);

        chk(exp_q.size() == 0, "R2 all pulses seen", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule